// File: doc/BRIEF.md
# Error Window Qualifier with Hysteresis

This block watches a stream of signed error samples and decides when the loop error has settled close to zero. Each valid sample may have its sign inverted. Inversion saturates, so the most negative code maps to the largest positive code. The sample is then tested against a symmetric window of plus or minus a programmable range. A counter qualifies the result. The settled flag sets once a programmable number of consecutive in-window samples has arrived. While it is set, it clears only after the same number of consecutive out-of-window samples. Set and clear therefore have matching hysteresis.

Configuration sits in one 18-bit control word with a write strobe and a continuous read-back. That word holds the polarity, the enable, the range and the sample limit. While the enable bit is set, the block asserts a ramp-inhibit output so that an external ramp generator stays idle during qualification. A three-state machine sequences the work:
- **OFF**: qualification is disabled.
- **HUNT**: the flag is clear and the block counts in-window samples.
- **HELD**: the flag is set and the block counts out-of-window samples.

Transitions:
- OFF to HUNT when enable is seen.
- HUNT to HELD when the in-window count reaches the limit.
- HELD to HUNT when the out-of-window count reaches the limit.
- Any state to OFF when enable is clear.

Top module: `err_settle_qual`

## Requirements
- R1: After reset the control word reads 18'h0FF00, `settled` is 0 and `ramp_inhibit` is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` on that clock edge, and `cfg_rdata` returns it from then on. Bit 17 is polarity, bit 16 is enable, bits 15:8 are the range and bits 7:0 are the limit.
- R3: The error after the polarity step is in-window exactly when it lies between minus range and plus range, both ends included.
- R4: While `settled` is 0, the flag sets on the edge that takes the limit-th consecutive valid in-window sample. Any valid out-of-window sample restarts that count.
- R5: While `settled` is 1, the flag clears on the edge that takes the limit-th consecutive valid out-of-window sample. Any valid in-window sample restarts that count.
- R6: With a limit of 0 or 1, `settled` follows the window result of the most recent valid sample from the edge that takes it.
- R7: Polarity 1 negates the error with saturation, so code 9'h100 (-256) becomes +255. Polarity 0 leaves the error unchanged.
- R8: While enable is 0, samples have no effect and both counters and the flag are cleared. After a write that clears enable, `settled` is 0 from the second clock edge onward.
- R9: `ramp_inhibit` equals the stored enable bit.
- R10: A cycle with `smp_valid` low changes neither the counters nor `settled`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 18 | Control word write data |
| cfg_rdata | output | 18 | Control word read-back |
| smp_valid | input | 1 | One-cycle strobe marking a valid error sample |
| smp_err | input | 9 | Signed two's-complement error sample |
| settled | output | 1 | Error has qualified as settled near zero |
| ramp_inhibit | output | 1 | Holds the external ramp off while qualification is enabled |

## Verification
The internal state of this block shows at the ports only through `settled`. A corrupted count therefore appears as a flag change that comes one or more samples too early or too late. Runs of exactly limit-minus-one samples with one breaking sample in between are used to expose off-by-one and missed-restart faults on the very edge they occur. Window and saturation faults are found by single samples at plus and minus range, at one past range, and at the most negative code. With a limit of zero, each of those samples shows up in `settled` on the next edge.

// File: rtl/errq_pkg.sv
package errq_pkg;

    typedef enum logic [1:0] {
        QS_OFF  = 2'd0,
        QS_HUNT = 2'd1,
        QS_HELD = 2'd2
    } qual_state_e;

endpackage

// File: rtl/errq_regs.sv
module errq_regs #(
    parameter int RNG_W = 8,
    parameter int LIM_W = 8,
    localparam int CFG_W = 2 + RNG_W + LIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic             pol,
    output logic             en,
    output logic [RNG_W-1:0] rng,
    output logic [LIM_W-1:0] lim
);

    // field positions: polarity on top, then enable, range, limit at bottom
    localparam int POL_BIT = CFG_W - 1;
    localparam int EN_BIT  = CFG_W - 2;
    localparam int RNG_LSB = LIM_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol <= 1'b0;
            en  <= 1'b0;
            rng <= '1;
            lim <= '0;
        end else if (wr_en) begin
            pol <= wr_data[POL_BIT];
            en  <= wr_data[EN_BIT];
            rng <= wr_data[RNG_LSB +: RNG_W];
            lim <= wr_data[LIM_W-1:0];
        end
    end

    assign rd_data = {pol, en, rng, lim};

endmodule

// File: rtl/errq_window.sv
module errq_window #(
    parameter int ERR_W = 9,
    parameter int RNG_W = 8
) (
    input  logic [ERR_W-1:0] err_in,
    input  logic             invert,
    input  logic [RNG_W-1:0] rng,
    output logic             in_win
);

    localparam logic [ERR_W-1:0] MIN_CODE = {1'b1, {(ERR_W-1){1'b0}}};
    localparam logic [ERR_W-1:0] MAX_CODE = {1'b0, {(ERR_W-1){1'b1}}};
    localparam int PAD_W = ERR_W + 1 - RNG_W;

    logic [ERR_W-1:0] adj;
    logic [ERR_W:0]   wide;
    logic [ERR_W:0]   mag;
    logic [ERR_W:0]   lim_wide;

    // sign inversion, saturating the single code that has no positive twin
    always_comb begin
        if (invert) begin
            if (err_in == MIN_CODE) begin
                adj = MAX_CODE;
            end else begin
                adj = (~err_in) + 1'b1;
            end
        end else begin
            adj = err_in;
        end
    end

    // magnitude in one extra bit so that |min| is representable
    always_comb begin
        wide = {adj[ERR_W-1], adj};
        if (wide[ERR_W]) begin
            mag = (~wide) + 1'b1;
        end else begin
            mag = wide;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign lim_wide = {{PAD_W{1'b0}}, rng};
        end else begin : g_trunc
            assign lim_wide = rng[ERR_W:0];
        end
    endgenerate

    assign in_win = (mag <= lim_wide);

endmodule

// File: rtl/errq_fsm.sv
module errq_fsm
    import errq_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             smp_valid,
    input  logic             in_win,
    input  logic [LIM_W-1:0] lim,
    output logic             settled
);

    qual_state_e      st_q, st_n;
    logic [LIM_W-1:0] cnt_q, cnt_n;
    logic [LIM_W:0]   cnt_inc;
    logic             reached;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign reached = (cnt_inc >= {1'b0, lim});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= QS_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // next state and counter
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (!en) begin
            st_n  = QS_OFF;
            cnt_n = '0;
        end else begin
            unique case (st_q)
                QS_OFF, QS_HUNT: begin
                    st_n = QS_HUNT;
                    if (smp_valid) begin
                        if (!in_win) begin
                            cnt_n = '0;
                        end else if (reached) begin
                            st_n  = QS_HELD;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt_inc[LIM_W-1:0];
                        end
                    end
                end
                QS_HELD: begin
                    if (smp_valid) begin
                        if (in_win) begin
                            cnt_n = '0;
                        end else if (reached) begin
                            st_n  = QS_HUNT;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt_inc[LIM_W-1:0];
                        end
                    end
                end
                default: begin
                    st_n  = QS_OFF;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        settled = (st_q == QS_HELD);
    end

endmodule

// File: rtl/err_settle_qual.sv
module err_settle_qual #(
    parameter int ERR_W = 9,
    parameter int RNG_W = 8,
    parameter int LIM_W = 8,
    localparam int CFG_W = 2 + RNG_W + LIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             smp_valid,
    input  logic [ERR_W-1:0] smp_err,
    output logic             settled,
    output logic             ramp_inhibit
);

    logic             pol;
    logic             en;
    logic [RNG_W-1:0] rng;
    logic [LIM_W-1:0] lim;
    logic             win_ok;

    errq_regs #(.RNG_W(RNG_W), .LIM_W(LIM_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .rd_data (cfg_rdata),
        .pol     (pol),
        .en      (en),
        .rng     (rng),
        .lim     (lim)
    );

    errq_window #(.ERR_W(ERR_W), .RNG_W(RNG_W)) u_window (
        .err_in (smp_err),
        .invert (pol),
        .rng    (rng),
        .in_win (win_ok)
    );

    errq_fsm #(.LIM_W(LIM_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .smp_valid (smp_valid),
        .in_win    (win_ok),
        .lim       (lim),
        .settled   (settled)
    );

    assign ramp_inhibit = en;

endmodule

// File: rtl/errq_chk.sv
module errq_chk #(
    parameter int ERR_W = 9,
    parameter int RNG_W = 8,
    parameter int LIM_W = 8,
    localparam int CFG_W = 2 + RNG_W + LIM_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             smp_valid,
    input logic [ERR_W-1:0] smp_err,
    input logic             settled,
    input logic             ramp_inhibit,
    input logic             win_ok
);

    logic             c_pol;
    logic             c_en;
    logic [RNG_W-1:0] c_rng;
    logic [LIM_W-1:0] c_lim;

    assign c_pol = cfg_rdata[CFG_W-1];
    assign c_en  = cfg_rdata[CFG_W-2];
    assign c_rng = cfg_rdata[LIM_W +: RNG_W];
    assign c_lim = cfg_rdata[LIM_W-1:0];

    // R4
    hunt_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!settled && ramp_inhibit && smp_valid && !win_ok) |=> !settled);

    // R5
    held_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && ramp_inhibit && smp_valid && win_ok) |=> settled);

    // R6
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_inhibit && smp_valid && c_lim == '0) |=> (settled == $past(win_ok)));

    // R7
    sat_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_pol && smp_err == {1'b1, {(ERR_W-1){1'b0}}} &&
         {1'b0, c_rng} >= (RNG_W+1)'((1 << (ERR_W-1)) - 1)) |-> win_ok);

    // R8
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c_en |=> !settled);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && c_en) |=> $stable(settled));

endmodule

bind err_settle_qual errq_chk #(.ERR_W(ERR_W), .RNG_W(RNG_W), .LIM_W(LIM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .smp_valid    (smp_valid),
    .smp_err      (smp_err),
    .settled      (settled),
    .ramp_inhibit (ramp_inhibit),
    .win_ok       (win_ok)
);

// File: tb/test_err_settle_qual.sv
module test_err_settle_qual;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [17:0] cfg_wdata = '0;
    logic [17:0] cfg_rdata;
    logic        smp_valid = 1'b0;
    logic [8:0]  smp_err = '0;
    logic        settled;
    logic        ramp_inhibit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bit 9 = expected settled, bits 8:0 = error; config: en, range 10, limit 3
    localparam logic [9:0] VEC [12] = '{
        10'h005, 10'h1F6, 10'h00B, 10'h000, 10'h003, 10'h3FD,
        10'h214, 10'h200, 10'h3F5, 10'h20B, 10'h032, 10'h00A
    };

    always #5 clk = ~clk;

    err_settle_qual i_err_settle_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .smp_valid    (smp_valid),
        .smp_err      (smp_err),
        .settled      (settled),
        .ramp_inhibit (ramp_inhibit)
    );

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic smp(input logic [8:0] e);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_err = e;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 rdata", cfg_rdata, 18'h0FF00);
        check("R1 settled", {17'b0, settled}, 18'h0);
        check("R1 inhibit", {17'b0, ramp_inhibit}, 18'h0);

        // R8: disabled, limit 0, range 5: in-window sample ignored
        wr(18'h00500);
        check("R2 readback", cfg_rdata, 18'h00500);
        smp(9'h000);
        check("R8 ignored while off", {17'b0, settled}, 18'h0);

        wr(18'h10500);
        check("R9 inhibit on", {17'b0, ramp_inhibit}, 18'h1);
        smp(9'h002);
        check("R6 limit0 in", {17'b0, settled}, 18'h1);
        smp(9'h009);
        check("R6 limit0 out", {17'b0, settled}, 18'h0);
        smp(9'h1FB);
        check("R3 minus range edge", {17'b0, settled}, 18'h1);
        smp(9'h006);
        check("R3 plus range+1", {17'b0, settled}, 18'h0);
        smp(9'h1FA);
        check("R3 minus range-1", {17'b0, settled}, 18'h0);
        smp(9'h005);
        check("R3 plus range edge", {17'b0, settled}, 18'h1);

        // R10: out-of-window value without strobe
        @(negedge clk);
        smp_valid = 1'b0;
        smp_err = 9'h0F0;
        @(negedge clk);
        check("R10 no strobe", {17'b0, settled}, 18'h1);

        // R7
        wr(18'h3FF00);
        smp(9'h100);
        check("R7 inverted min saturates", {17'b0, settled}, 18'h1);
        wr(18'h1FF00);
        smp(9'h100);
        check("R7 plain min out", {17'b0, settled}, 18'h0);
        smp(9'h0FF);
        check("R3 max code in", {17'b0, settled}, 18'h1);

        // disable to restart, then table with limit 3
        wr(18'h00A03);
        @(negedge clk);
        check("R8 off clears", {17'b0, settled}, 18'h0);
        check("R9 inhibit off", {17'b0, ramp_inhibit}, 18'h0);
        wr(18'h10A03);
        for (int i = 0; i < 12; i++) begin
            smp(VEC[i][8:0]);
            check((i < 6) ? "R4 set count" : "R5 clear count",
                  {17'b0, settled}, {17'b0, VEC[i][9]});
        end

        // bring flag up then disable
        smp(9'h000);
        smp(9'h000);
        check("R4 set after restart", {17'b0, settled}, 18'h1);
        wr(18'h00A03);
        @(negedge clk);
        check("R8 disable drops flag", {17'b0, settled}, 18'h0);

        wr(18'h2A5C3);
        check("R2 readback pattern", cfg_rdata, 18'h2A5C3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule